// File: doc/BRIEF.md
# Ethernet Transmit Descriptor Sequencer

This block feeds a transmit MAC from a ring of descriptors in system memory. Software fills descriptor slots and moves a produce index forward. Whenever the produce index differs from the block's consume index, the block reads the descriptor at the consume slot through a one-word memory read port. Each descriptor is two words: a buffer pointer, then a control word. The block then asks the MAC side to fetch that buffer.

A frame may be split over several descriptors, and a Last flag marks its final fragment. The frame options (pad, CRC, unlimited length) come from the first fragment of each frame. They are taken either from that descriptor or from default inputs, chosen by the descriptor's override bit. They then stay fixed until the frame ends.

For every descriptor the block writes one status word into a status array, then advances the consume index. If the descriptor asks for it, the block raises a done pulse, and only after the status write has been acknowledged. A frame that is not marked unlimited and grows past the programmed maximum length is cut. The fragment that overflows it, and every later fragment up to the Last one, is skipped rather than fetched, and its status carries an error flag.

Top module: `txDescSeq`

## Requirements
- R1: While reset is held, consumeIdx reads 0, and memRdReq, fetchValid, statWrEn and txDoneIrq are all low.
- R2: While produceIdx equals consumeIdx, the block issues no memory reads.
- R3: For slot i, the block reads the buffer pointer at descBase+8*i and then the control word at descBase+8*i+4. A read request holds its address stable until memRdAck.
- R4: The control word is decoded as follows. Bits 10:0 hold the fragment length minus one. Bit 26 is the override flag, bit 27 allows unlimited length, bit 28 asks for padding, bit 29 asks for CRC, bit 30 marks the Last fragment and bit 31 requests the done pulse. Bits 25:11 have no effect. For a fragment that is fetched, fetchAddr equals the buffer pointer, fetchBytes equals bits 10:0 plus one, and fetchLast equals bit 30. The request stays stable until fetchReady.
- R5: On the first fragment of a frame, if bit 26 is set, bits 27, 28 and 29 set the unlimited-length, pad and CRC options. If bit 26 is clear, those bits have no effect and defHuge, defPad and defCrc apply.
- R6: framePad and frameCrc keep the values chosen on a frame's first fragment for every later fragment of that frame, whatever those later descriptors hold.
- R7: In a frame that is not unlimited, a fragment whose running byte total (this fragment included) exceeds maxFrameLen is not fetched. Every later fragment through the next Last one is not fetched either. A total equal to maxFrameLen is still fetched.
- R8: Each descriptor gets one status write to statBase+4*i. The status word holds bit 31 = skipped with error, bit 30 = Last, and bits 10:0 = the length field. All other bits are 0.
- R9: txDoneIrq is a one-cycle pulse. It comes in the cycle after a status write is acknowledged, and only when bit 31 of that descriptor is set.
- R10: consumeIdx advances by one after each status write and wraps from ringCount-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descBase | input | 32 | Byte address of descriptor slot 0 (8-byte aligned) |
| statBase | input | 32 | Byte address of status slot 0 |
| ringCount | input | IDXW | Number of slots in the ring |
| produceIdx | input | IDXW | Slot after the last one filled by software |
| consumeIdx | output | IDXW | Next slot the block will handle |
| maxFrameLen | input | 16 | Byte limit for frames that are not unlimited |
| defPad | input | 1 | Default pad option |
| defCrc | input | 1 | Default CRC option |
| defHuge | input | 1 | Default unlimited-length option |
| memRdReq | output | 1 | Memory read request |
| memRdAddr | output | 32 | Memory read byte address |
| memRdAck | input | 1 | Read accepted; memRdData is valid |
| memRdData | input | 32 | Read data |
| fetchValid | output | 1 | Buffer fetch request |
| fetchReady | input | 1 | Fetch request accepted |
| fetchAddr | output | 32 | Buffer start address |
| fetchBytes | output | LENW+1 | Buffer length in bytes |
| fetchLast | output | 1 | Fragment ends the frame |
| framePad | output | 1 | Pad option for the current frame |
| frameCrc | output | 1 | CRC option for the current frame |
| fragSent | input | 1 | Pulse: accepted fragment has been transmitted |
| statWrEn | output | 1 | Status write request |
| statWrAddr | output | 32 | Status write byte address |
| statWrData | output | 32 | Status word |
| statWrAck | input | 1 | Status write committed |
| txDoneIrq | output | 1 | Done pulse |

## Verification
The bench keeps the defaults IDXW=4 and LENW=11 and drives ringCount to 6. Runs of up to four descriptors therefore wrap the consume index many times, and the slot 5 to 0 step is exercised often. maxFrameLen is set to 100 for the directed cases and 150 for the random ones. With fragments of up to 64 bytes, frames often cross the limit in the middle. This reaches the discard path, the exact-limit boundary and recovery on the next frame, all without long buffers.

// File: rtl/txSeqPkg.sv
`timescale 1ns/1ps
package txSeqPkg;
  // Control word bit positions (decoded by this block and by software)
  localparam int CTL_OVR  = 26;
  localparam int CTL_HUGE = 27;
  localparam int CTL_PAD  = 28;
  localparam int CTL_CRC  = 29;
  localparam int CTL_LAST = 30;
  localparam int CTL_INT  = 31;

  typedef struct packed {
    logic capPtr;    // latch buffer pointer from read data
    logic capCtl;    // latch control word from read data
    logic ctlPhase;  // read address selects the control word
    logic evalFrag;  // evaluate the fragment against the frame state
    logic advance;   // step the consume index
  } seqStrobes_t;

  typedef struct packed {
    logic huge;
    logic pad;
    logic crc;
  } frameOpts_t;
endpackage

// File: rtl/txSeqCtrl.sv
`timescale 1ns/1ps
module txSeqCtrl
  import txSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pending,
  input  logic        dropNow,
  input  logic        irqWanted,
  input  logic        memRdAck,
  input  logic        fetchReady,
  input  logic        fragSent,
  input  logic        statWrAck,
  output seqStrobes_t stb,
  output logic        memRdReq,
  output logic        fetchValid,
  output logic        statWrEn,
  output logic        txDoneIrq
);
  typedef enum logic [2:0] {
    S_IDLE, S_RDPTR, S_RDCTL, S_DECIDE, S_FETCH, S_WAITSENT, S_STAT, S_DONE
  } seqState_t;

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:     if (pending)    stateNext = S_RDPTR;
      S_RDPTR:    if (memRdAck)   stateNext = S_RDCTL;
      S_RDCTL:    if (memRdAck)   stateNext = S_DECIDE;
      S_DECIDE:   stateNext = dropNow ? S_STAT : S_FETCH;
      S_FETCH:    if (fetchReady) stateNext = S_WAITSENT;
      S_WAITSENT: if (fragSent)   stateNext = S_STAT;
      S_STAT:     if (statWrAck)  stateNext = S_DONE;
      S_DONE:     stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    stb.capPtr   = (state == S_RDPTR) && memRdAck;
    stb.capCtl   = (state == S_RDCTL) && memRdAck;
    stb.ctlPhase = (state == S_RDCTL);
    stb.evalFrag = (state == S_DECIDE);
    stb.advance  = (state == S_DONE);
  end

  assign memRdReq   = (state == S_RDPTR) || (state == S_RDCTL);
  assign fetchValid = (state == S_FETCH);
  assign statWrEn   = (state == S_STAT);
  assign txDoneIrq  = (state == S_DONE) && irqWanted;
endmodule

// File: rtl/txSeqDatapath.sv
`timescale 1ns/1ps
module txSeqDatapath
  import txSeqPkg::*;
#(
  parameter int IDXW = 4,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobes_t     stb,
  input  logic [31:0]     descBase,
  input  logic [31:0]     statBase,
  input  logic [IDXW-1:0] ringCount,
  input  logic [IDXW-1:0] produceIdx,
  input  logic [15:0]     maxFrameLen,
  input  logic            defPad,
  input  logic            defCrc,
  input  logic            defHuge,
  input  logic [31:0]     memRdData,
  output logic [IDXW-1:0] consumeIdx,
  output logic [31:0]     memRdAddr,
  output logic [31:0]     statWrAddr,
  output logic [31:0]     statWrData,
  output logic [31:0]     fetchAddr,
  output logic [LENW:0]   fetchBytes,
  output logic            fetchLast,
  output logic            framePad,
  output logic            frameCrc,
  output logic            pending,
  output logic            dropNow,
  output logic            irqWanted
);
  localparam int TOTW = 17;            // room for limit plus one fragment
  localparam int HIW  = 32 - CTL_OVR;  // control bits 31:26
  localparam int GAPW = 30 - LENW;     // zero gap inside the status word

  logic [IDXW-1:0] lastIdx;
  logic [31:0]     bufPtr;
  logic [LENW-1:0] fragLen;
  logic [HIW-1:0]  ctlHi;
  logic            inFrame, discard, errFlag;
  logic [TOTW-1:0] frameBytes, newTotal;
  frameOpts_t      optsLatched, optsNew, optsUse;
  logic            unusedCtlBits;

  assign unusedCtlBits = ^memRdData[CTL_OVR-1:LENW];
  assign lastIdx = ringCount - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      consumeIdx <= '0;
    end else if (stb.advance) begin
      consumeIdx <= (consumeIdx == lastIdx) ? '0 : consumeIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufPtr  <= '0;
      fragLen <= '0;
      ctlHi   <= '0;
    end else begin
      if (stb.capPtr) bufPtr <= memRdData;
      if (stb.capCtl) begin
        fragLen <= memRdData[LENW-1:0];
        ctlHi   <= memRdData[31:CTL_OVR];
      end
    end
  end

  // Options the first fragment would select
  always_comb begin
    if (ctlHi[CTL_OVR-CTL_OVR]) begin
      optsNew.huge = ctlHi[CTL_HUGE-CTL_OVR];
      optsNew.pad  = ctlHi[CTL_PAD-CTL_OVR];
      optsNew.crc  = ctlHi[CTL_CRC-CTL_OVR];
    end else begin
      optsNew.huge = defHuge;
      optsNew.pad  = defPad;
      optsNew.crc  = defCrc;
    end
    optsUse  = inFrame ? optsLatched : optsNew;
    newTotal = frameBytes + TOTW'(fragLen) + TOTW'(1);
    dropNow  = discard || (!optsUse.huge && (newTotal > TOTW'(maxFrameLen)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame     <= 1'b0;
      discard     <= 1'b0;
      frameBytes  <= '0;
      errFlag     <= 1'b0;
      optsLatched <= '0;
    end else if (stb.evalFrag) begin
      if (!inFrame) optsLatched <= optsNew;
      errFlag <= dropNow;
      if (ctlHi[CTL_LAST-CTL_OVR]) begin
        inFrame    <= 1'b0;
        discard    <= 1'b0;
        frameBytes <= '0;
      end else begin
        inFrame    <= 1'b1;
        discard    <= dropNow;
        frameBytes <= newTotal;
      end
    end
  end

  assign pending    = (produceIdx != consumeIdx);
  assign irqWanted  = ctlHi[CTL_INT-CTL_OVR];
  assign memRdAddr  = descBase + (32'(consumeIdx) << 3) + (stb.ctlPhase ? 32'd4 : 32'd0);
  assign statWrAddr = statBase + (32'(consumeIdx) << 2);
  assign statWrData = {errFlag, ctlHi[CTL_LAST-CTL_OVR], {GAPW{1'b0}}, fragLen};
  assign fetchAddr  = bufPtr;
  assign fetchBytes = {1'b0, fragLen} + 1'b1;
  assign fetchLast  = ctlHi[CTL_LAST-CTL_OVR];
  assign framePad   = optsLatched.pad;
  assign frameCrc   = optsLatched.crc;
endmodule

// File: rtl/txDescSeq.sv
`timescale 1ns/1ps
module txDescSeq
  import txSeqPkg::*;
#(
  parameter int IDXW = 4,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     descBase,
  input  logic [31:0]     statBase,
  input  logic [IDXW-1:0] ringCount,
  input  logic [IDXW-1:0] produceIdx,
  output logic [IDXW-1:0] consumeIdx,
  input  logic [15:0]     maxFrameLen,
  input  logic            defPad,
  input  logic            defCrc,
  input  logic            defHuge,
  output logic            memRdReq,
  output logic [31:0]     memRdAddr,
  input  logic            memRdAck,
  input  logic [31:0]     memRdData,
  output logic            fetchValid,
  input  logic            fetchReady,
  output logic [31:0]     fetchAddr,
  output logic [LENW:0]   fetchBytes,
  output logic            fetchLast,
  output logic            framePad,
  output logic            frameCrc,
  input  logic            fragSent,
  output logic            statWrEn,
  output logic [31:0]     statWrAddr,
  output logic [31:0]     statWrData,
  input  logic            statWrAck,
  output logic            txDoneIrq
);
  seqStrobes_t stb;
  logic pending, dropNow, irqWanted;

  txSeqCtrl u_ctrl (
    .clk, .rstN, .pending, .dropNow, .irqWanted, .memRdAck, .fetchReady,
    .fragSent, .statWrAck, .stb, .memRdReq, .fetchValid, .statWrEn, .txDoneIrq
  );

  txSeqDatapath #(.IDXW(IDXW), .LENW(LENW)) u_dp (
    .clk, .rstN, .stb, .descBase, .statBase, .ringCount, .produceIdx,
    .maxFrameLen, .defPad, .defCrc, .defHuge, .memRdData, .consumeIdx,
    .memRdAddr, .statWrAddr, .statWrData, .fetchAddr, .fetchBytes, .fetchLast,
    .framePad, .frameCrc, .pending, .dropNow, .irqWanted
  );
endmodule

// File: rtl/txSeqChecker.sv
`timescale 1ns/1ps
module txSeqChecker #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [31:0]     descBase,
  input logic [31:0]     statBase,
  input logic [IDXW-1:0] consumeIdx,
  input logic            memRdReq,
  input logic            memRdAck,
  input logic [31:0]     memRdAddr,
  input logic            fetchValid,
  input logic            fetchReady,
  input logic [31:0]     fetchAddr,
  input logic            statWrEn,
  input logic            statWrAck,
  input logic [31:0]     statWrAddr,
  input logic            txDoneIrq
);
  logic [31:0] slotAddr;
  assign slotAddr = descBase + (32'(consumeIdx) << 3);

  assert_rd_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (memRdAddr == slotAddr || memRdAddr == slotAddr + 32'd4));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdAck |=> memRdReq && $stable(memRdAddr));

  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !fetchReady |=> fetchValid && $stable(fetchAddr));

  assert_stat_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    statWrEn |-> statWrAddr == statBase + (32'(consumeIdx) << 2));

  assert_irq_after_stat_R9: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |-> $past(statWrEn && statWrAck));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |=> !txDoneIrq);

  assert_idx_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(consumeIdx) |-> (consumeIdx == $past(consumeIdx) + 1'b1 || consumeIdx == '0));
endmodule

bind txDescSeq txSeqChecker #(.IDXW(IDXW)) u_txSeqChecker (
  .clk(clk), .rstN(rstN), .descBase(descBase), .statBase(statBase),
  .consumeIdx(consumeIdx), .memRdReq(memRdReq), .memRdAck(memRdAck),
  .memRdAddr(memRdAddr), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .fetchAddr(fetchAddr), .statWrEn(statWrEn), .statWrAck(statWrAck),
  .statWrAddr(statWrAddr), .txDoneIrq(txDoneIrq)
);

// File: tb/txDescSeq_bench.sv
`timescale 1ns/1ps
module txDescSeq_bench;
  localparam int IDXW = 4;
  localparam int LENW = 11;
  localparam logic [31:0] DBASE = 32'h0000_1000;
  localparam logic [31:0] SBASE = 32'h0000_2000;
  localparam int RING = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rstN;
  logic [IDXW-1:0] ringCount, produceIdx, consumeIdx;
  logic [15:0]     maxFrameLen;
  logic            defPad, defCrc, defHuge;
  logic            memRdReq, memRdAck;
  logic [31:0]     memRdAddr, memRdData;
  logic            fetchValid, fetchReady, fetchLast, framePad, frameCrc, fragSent;
  logic [31:0]     fetchAddr;
  logic [LENW:0]   fetchBytes;
  logic            statWrEn, statWrAck, txDoneIrq;
  logic [31:0]     statWrAddr, statWrData;

  txDescSeq #(.IDXW(IDXW), .LENW(LENW)) u_txDescSeq (
    .clk, .rstN, .descBase(DBASE), .statBase(SBASE), .ringCount, .produceIdx,
    .consumeIdx, .maxFrameLen, .defPad, .defCrc, .defHuge, .memRdReq, .memRdAddr,
    .memRdAck, .memRdData, .fetchValid, .fetchReady, .fetchAddr, .fetchBytes,
    .fetchLast, .framePad, .frameCrc, .fragSent, .statWrEn, .statWrAddr,
    .statWrData, .statWrAck, .txDoneIrq
  );

  int nChecks = 0, nFail = 0, cycles = 0;
  int rdSeen = 0, irqSeen = 0, expIrq = 0, sentDelay = 0;
  logic [31:0] descPtr [16];
  logic [31:0] descCtl [16];
  int pIdx = 0;

  // reference frame state
  int mSlot = 0, mBytes = 0;
  bit mInFrame = 0, mDiscard = 0, mPad = 0, mCrc = 0, mHuge = 0, lastIrqBit = 0;
  // recorded fetch
  bit fSeen = 0, fLast = 0, fPad = 0, fCrc = 0;
  logic [31:0] fAddr;
  int fBytes = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int len, input bit ovr, input bit huge, input bit pad,
                                     input bit crc, input bit last, input bit intr, input logic [14:0] junk);
    return {intr, last, crc, pad, huge, ovr, junk, 11'(len)};
  endfunction

  // Reference step for one descriptor, checked when its status is written
  task automatic refStatus();
    logic [31:0] ctl = descCtl[mSlot];
    bit drop, over;
    int tot;
    if (!mInFrame) begin
      mHuge = ctl[26] ? ctl[27] : defHuge;
      mPad  = ctl[26] ? ctl[28] : defPad;
      mCrc  = ctl[26] ? ctl[29] : defCrc;
    end
    tot  = mBytes + int'(ctl[10:0]) + 1;
    over = !mHuge && (tot > int'(maxFrameLen));
    drop = mDiscard || over;
    chk(statWrAddr == SBASE + 32'(4 * mSlot), "R8 status address", statWrAddr, SBASE + 32'(4 * mSlot));
    chk(statWrData == {drop, ctl[30], 19'b0, ctl[10:0]}, "R8/R7 status word",
        statWrData, {drop, ctl[30], 19'b0, ctl[10:0]});
    chk(fSeen == !drop, "R7 fetch issued vs skipped", 32'(fSeen), 32'(!drop));
    if (fSeen && !drop) begin
      chk(fAddr == descPtr[mSlot], "R4 fetch address", fAddr, descPtr[mSlot]);
      chk(fBytes == int'(ctl[10:0]) + 1, "R4 fetch bytes", 32'(fBytes), 32'(int'(ctl[10:0]) + 1));
      chk(fLast == ctl[30], "R4 fetch last", 32'(fLast), 32'(ctl[30]));
      chk(fPad == mPad && fCrc == mCrc, "R5 R6 frame options", {30'b0, fPad, fCrc}, {30'b0, mPad, mCrc});
    end
    if (ctl[30]) begin
      mInFrame = 0; mDiscard = 0; mBytes = 0;
    end else begin
      mInFrame = 1; mDiscard = drop; mBytes = tot;
    end
    if (ctl[31]) expIrq++;
    lastIrqBit = ctl[31];
    fSeen = 0;
    mSlot = (mSlot == RING - 1) ? 0 : mSlot + 1;
  endtask

  // Memory, MAC and status responders, plus watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
    if (!rstN) begin
      memRdAck = 0; fetchReady = 0; fragSent = 0; statWrAck = 0; sentDelay = 0;
    end else begin
      if (memRdReq) rdSeen++;
      if (txDoneIrq) begin
        irqSeen++;
        chk(lastIrqBit == 1'b1, "R9 pulse only when requested", 32'(txDoneIrq), 32'(lastIrqBit));
      end
      if (memRdAck) memRdAck = 0;
      else if (memRdReq && ($urandom % 4 != 0)) begin
        chk(memRdAddr == DBASE + 32'(8 * mSlot) || memRdAddr == DBASE + 32'(8 * mSlot + 4),
            "R3 descriptor address", memRdAddr, DBASE + 32'(8 * mSlot));
        memRdData = memRdAddr[2] ? descCtl[mSlot] : descPtr[mSlot];
        memRdAck = 1;
      end
      fragSent = 0;
      if (sentDelay > 0) begin
        sentDelay--;
        if (sentDelay == 0) fragSent = 1;
      end
      if (fetchReady) fetchReady = 0;
      else if (fetchValid && ($urandom % 3 != 0)) begin
        fSeen = 1; fAddr = fetchAddr; fBytes = int'(fetchBytes);
        fLast = fetchLast; fPad = framePad; fCrc = frameCrc;
        fetchReady = 1;
        sentDelay = 1 + int'($urandom % 4);
      end
      if (statWrAck) statWrAck = 0;
      else if (statWrEn && ($urandom % 3 != 0)) begin
        refStatus();
        statWrAck = 1;
      end
    end
  end

  task automatic push(input logic [31:0] ptr, input logic [31:0] ctl);
    descPtr[pIdx] = ptr;
    descCtl[pIdx] = ctl;
    pIdx = (pIdx == RING - 1) ? 0 : pIdx + 1;
  endtask

  task automatic go(input string tag);
    int guard = 0;
    @(negedge clk);
    produceIdx = IDXW'(pIdx);
    while ((consumeIdx != IDXW'(pIdx) || statWrEn || fetchValid) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(consumeIdx == IDXW'(pIdx), {"R10 consume index after ", tag}, 32'(consumeIdx), 32'(pIdx));
    chk(irqSeen == expIrq, {"R9 pulse count after ", tag}, 32'(irqSeen), 32'(expIrq));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; produceIdx = '0; ringCount = IDXW'(RING);
    maxFrameLen = 16'd1500; defPad = 0; defCrc = 0; defHuge = 0;
    memRdAck = 0; memRdData = '0; fetchReady = 0; fragSent = 0; statWrAck = 0;
    repeat (5) @(negedge clk);
    chk(consumeIdx == '0, "R1 reset index", 32'(consumeIdx), 0);
    chk({memRdReq, fetchValid, statWrEn, txDoneIrq} == 4'b0, "R1 reset outputs",
        {28'b0, memRdReq, fetchValid, statWrEn, txDoneIrq}, 0);
    rstN = 1;

    // R2: nothing pending, no reads
    repeat (20) @(negedge clk);
    chk(rdSeen == 0, "R2 idle reads", 32'(rdSeen), 0);

    // R5: override clear, descriptor bits ignored, defaults used; junk in 25:11
    defPad = 1; defCrc = 1; defHuge = 0;
    push(32'hA000_0003, mk(9, 0, 1, 0, 0, 1, 1, 15'h7ABC));
    go("defaults R5");

    // R6: two fragments, second tries other options
    defPad = 0; defCrc = 0;
    push(32'hB000_0000, mk(19, 1, 0, 1, 0, 0, 0, 15'h0));
    push(32'hB100_0001, mk(7, 1, 1, 0, 1, 1, 1, 15'h0));
    go("latched options R6");

    // R7: overflow mid-frame then recovery
    maxFrameLen = 16'd100;
    push(32'hC000_0000, mk(59, 0, 0, 0, 0, 0, 0, 15'h0));
    push(32'hC100_0000, mk(59, 0, 0, 0, 0, 0, 1, 15'h0));
    push(32'hC200_0000, mk(9, 0, 0, 0, 0, 1, 1, 15'h0));
    push(32'hC300_0000, mk(29, 0, 0, 0, 0, 1, 0, 15'h0));
    go("overflow R7");

    // unlimited frame via override passes the limit
    push(32'hD000_0000, mk(59, 1, 1, 0, 1, 0, 0, 15'h0));
    push(32'hD100_0000, mk(59, 0, 0, 0, 0, 0, 0, 15'h0));
    push(32'hD200_0000, mk(9, 0, 0, 0, 0, 1, 1, 15'h0));
    go("unlimited R7");

    // R7 boundary: exactly the limit, then one over
    push(32'hE000_0000, mk(99, 0, 0, 0, 0, 1, 0, 15'h0));
    push(32'hE100_0000, mk(100, 0, 0, 0, 0, 1, 1, 15'h0));
    go("boundary R7");

    // random batches (wrap the ring many times, R10)
    maxFrameLen = 16'd150;
    for (int b = 0; b < 40; b++) begin
      int n = 1 + int'($urandom % 4);
      defPad = 1'($urandom); defCrc = 1'($urandom); defHuge = ($urandom % 5 == 0);
      for (int k = 0; k < n; k++) begin
        bit lastF = (k == n - 1) ? 1'b1 : 1'($urandom);
        push($urandom, mk(int'($urandom % 64), 1'($urandom), ($urandom % 4 == 0), 1'($urandom),
                          1'($urandom), lastF, 1'($urandom), 15'($urandom)));
      end
      go("random R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule